// File: doc/BRIEF.md
# Inter-Processor Mailbox Slot

This block is one mailbox slot shared by up to `N_CHAN` processor cores. Each core has one or more one-hot channel identifiers. A core that wants to send a message claims the slot by writing one of its identifiers into the owner register. It then reads that register back. If the value it reads matches its own identifier, the claim succeeded. Once the slot has an owner, every further non-zero write to the owner register is dropped, so two cores can never hold the slot at the same time.

The owner chooses the receiving cores in a target register and the enabled interrupts in an enable register. Each of these registers has separate set and clear addresses, so single bits change without a read-modify-write. Writing 1 to the send register raises a pending flag. Interrupt line `i` is high while pending is set and bit `i` is set in both the target and the enable register. Writing zero to the owner register releases the slot and wipes all of its state.

Register word offsets on `bus_addr`:

| Offset | Register |
|---|---|
| 0 | owner |
| 1 | target set |
| 2 | target clear |
| 3 | target read |
| 4 | enable set |
| 5 | enable clear |
| 6 | enable read |
| 7 | send (bit 0) |

All accesses are single-cycle. `bus_rdata` follows `bus_addr` combinationally.

Top module: `ipc_mailbox`

## Requirements
- R1: After synchronous active-low reset, every register reads 0 at offsets 0, 3, 6 and 7, and all `irq_out` bits are 0.
- R2: A write to offset 0 while the owner register is zero stores the written value exactly as given, including values that are not one-hot, and it reads back at offset 0 from the next cycle.
- R3: While the owner register is non-zero, a non-zero write to offset 0 leaves it unchanged, so a losing core reads back a value other than its own identifier.
- R4: Writing zero to offset 0 clears the owner register, the target register, the enable register and the pending flag on the next clock edge.
- R5: While owned, a write to offset 1 ORs the written value into the target register, which reads at offset 3.
- R6: While owned, a write to offset 2 clears in the target register every bit that is set in the written value, and leaves the other bits unchanged.
- R7: While owned, writes to offset 4 and offset 5 OR bits into, and clear bits from, the enable register, which reads at offset 6.
- R8: While the owner register is zero, writes to offsets 1, 2, 4, 5 and 7 have no effect.
- R9: While owned, a write to offset 7 sets the pending flag to bit 0 of the written value. Pending reads as bit 0 at offset 7.
- R10: `irq_out[i]` is 1 exactly when pending is set and bit `i` is set in both the target and the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | N_CHAN | Write data |
| bus_rdata | output | N_CHAN | Read data for `bus_addr` |
| irq_out | output | N_CHAN | One interrupt line per channel |

## Verification
Embedded assertions check four rules on every cycle. An occupied owner register holds its value against non-zero writes. Set and clear writes leave the written bits set or cleared. The target and enable registers, and pending, stay zero while the slot has no owner. No interrupt fires without pending. Only the bench's scenarios can show the full claim handshake: two cores contending, one winning and the other seeing a foreign identifier on read-back. The same holds for the exact interrupt pattern after mixed set and clear sequences, and for a fresh claim after release starting from a wiped slot. A behavioural model compares every read and the interrupt lines on every clock, across directed sequences and a random write stream.

// File: rtl/ipc_mbx_pkg.sv
// Package: shared widths and the register offset map of the mailbox slot.
// Assumes word-addressed single-cycle accesses.
package ipc_mbx_pkg;
    localparam int MBX_ADDR_W = 3;

    typedef enum logic [MBX_ADDR_W-1:0] {
        OFF_OWNER   = 3'd0,
        OFF_TGT_SET = 3'd1,
        OFF_TGT_CLR = 3'd2,
        OFF_TGT_RD  = 3'd3,
        OFF_EN_SET  = 3'd4,
        OFF_EN_CLR  = 3'd5,
        OFF_EN_RD   = 3'd6,
        OFF_SEND    = 3'd7
    } mbx_off_e;
endpackage

// File: rtl/ipc_mbx_owner.sv
// Module: owner register of the mailbox slot.
// Loads any value while empty; once non-zero it accepts only an all-zero write
// (release). No one-hot checking is done; software guarantees the encoding.
module ipc_mbx_owner #(
    parameter int N_CHAN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [N_CHAN-1:0] wdata,
    output logic [N_CHAN-1:0] owner,
    output logic              owned
);
    logic [N_CHAN-1:0] owner_q;

    // Purpose: accept a claim while empty, or a release at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= '0;
        end else if (wr_stb && ((owner_q == '0) || (wdata == '0))) begin
            owner_q <= wdata;
        end
    end

    assign owner = owner_q;
    assign owned = (owner_q != '0);

    AST_HOLD_WHILE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        (owned && wr_stb && (wdata != '0)) |=> $stable(owner_q)); // R3
    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (wdata == '0)) |=> (owner_q == '0)); // R4
endmodule

// File: rtl/ipc_mbx_bitreg.sv
// Module: N-bit register changed only through set (OR) and clear (AND-NOT)
// strobes. Set and clear are gated by the ownership flag; a wipe resets it.
// Assumes set, clear and wipe never coincide (distinct bus offsets).
module ipc_mbx_bitreg #(
    parameter int N_CHAN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe,
    input  logic              allow,
    input  logic              set_stb,
    input  logic              clr_stb,
    input  logic [N_CHAN-1:0] wdata,
    output logic [N_CHAN-1:0] value
);
    logic [N_CHAN-1:0] val_q;

    // Purpose: apply wipe, then gated set or clear of individual bits.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            val_q <= '0;
        end else if (allow && set_stb) begin
            val_q <= val_q | wdata;
        end else if (allow && clr_stb) begin
            val_q <= val_q & ~wdata;
        end
    end

    assign value = val_q;

    AST_SET_BITS_STICK: assert property (@(posedge clk) disable iff (!rst_n)
        (allow && set_stb && !wipe) |=> ((val_q & $past(wdata)) == $past(wdata))); // R5
    AST_CLR_BITS_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        (allow && clr_stb && !wipe) |=> ((val_q & $past(wdata)) == '0)); // R6
    AST_EMPTY_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !allow |-> (val_q == '0)); // R8
endmodule

// File: rtl/ipc_mbx_irq.sv
// Module: send-pending flag and per-channel interrupt generation.
// Pending follows bit 0 of send writes while owned; wipe clears it.
module ipc_mbx_irq #(
    parameter int N_CHAN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe,
    input  logic              allow,
    input  logic              send_stb,
    input  logic              send_bit,
    input  logic [N_CHAN-1:0] target,
    input  logic [N_CHAN-1:0] enable,
    output logic              pending,
    output logic [N_CHAN-1:0] irq
);
    logic pend_q;

    // Purpose: track the send trigger, gated by ownership.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            pend_q <= 1'b0;
        end else if (allow && send_stb) begin
            pend_q <= send_bit;
        end
    end

    // Purpose: route pending to every channel that is both targeted and enabled.
    always_comb begin
        irq = pend_q ? (target & enable) : '0;
    end

    assign pending = pend_q;

    AST_SEND_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!allow && send_stb) |=> !pend_q); // R8
    AST_PEND_NEEDS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> allow); // R9
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q |-> (irq == '0)); // R10
endmodule

// File: rtl/ipc_mailbox.sv
// Module: top of the mailbox slot. Decodes the single-cycle register bus,
// instantiates owner, target, enable and interrupt logic, muxes read data.
// Assumes at most one write per cycle; reads have no side effects.
module ipc_mailbox
    import ipc_mbx_pkg::*;
#(
    parameter int N_CHAN = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [MBX_ADDR_W-1:0] bus_addr,
    input  logic [N_CHAN-1:0]     bus_wdata,
    output logic [N_CHAN-1:0]     bus_rdata,
    output logic [N_CHAN-1:0]     irq_out
);
    localparam int N_PAD = N_CHAN - 1;

    logic [N_CHAN-1:0] owner, target, enable;
    logic              owned, pending, wipe;
    logic              wr_owner, wr_tset, wr_tclr, wr_eset, wr_eclr, wr_send;

    // Purpose: one strobe per writable offset.
    always_comb begin
        wr_owner = bus_wr && (bus_addr == OFF_OWNER);
        wr_tset  = bus_wr && (bus_addr == OFF_TGT_SET);
        wr_tclr  = bus_wr && (bus_addr == OFF_TGT_CLR);
        wr_eset  = bus_wr && (bus_addr == OFF_EN_SET);
        wr_eclr  = bus_wr && (bus_addr == OFF_EN_CLR);
        wr_send  = bus_wr && (bus_addr == OFF_SEND);
        wipe     = wr_owner && (bus_wdata == '0);
    end

    ipc_mbx_owner #(.N_CHAN(N_CHAN)) u_owner (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_owner), .wdata(bus_wdata),
        .owner(owner), .owned(owned)
    );

    ipc_mbx_bitreg #(.N_CHAN(N_CHAN)) u_target (
        .clk(clk), .rst_n(rst_n), .wipe(wipe), .allow(owned),
        .set_stb(wr_tset), .clr_stb(wr_tclr), .wdata(bus_wdata), .value(target)
    );

    ipc_mbx_bitreg #(.N_CHAN(N_CHAN)) u_enable (
        .clk(clk), .rst_n(rst_n), .wipe(wipe), .allow(owned),
        .set_stb(wr_eset), .clr_stb(wr_eclr), .wdata(bus_wdata), .value(enable)
    );

    ipc_mbx_irq #(.N_CHAN(N_CHAN)) u_irq (
        .clk(clk), .rst_n(rst_n), .wipe(wipe), .allow(owned),
        .send_stb(wr_send), .send_bit(bus_wdata[0]),
        .target(target), .enable(enable), .pending(pending), .irq(irq_out)
    );

    // Purpose: return the addressed register; write-only offsets read zero.
    always_comb begin
        case (bus_addr)
            OFF_OWNER:  bus_rdata = owner;
            OFF_TGT_RD: bus_rdata = target;
            OFF_EN_RD:  bus_rdata = enable;
            OFF_SEND:   bus_rdata = {{N_PAD{1'b0}}, pending};
            default:    bus_rdata = '0;
        endcase
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0)); // R1
endmodule

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] irq_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    logic [N-1:0] m_own = '0, m_tgt = '0, m_en = '0;
    bit           m_pend = 1'b0;

    always #5 clk = ~clk;

    ipc_mailbox #(.N_CHAN(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference: behavioural effect of one bus write
    task automatic model_write(input int a, input logic [N-1:0] d);
        bit held = (m_own != 0);
        case (a)
            0: if (!held) m_own = d;
               else if (d == 0) begin m_own = 0; m_tgt = 0; m_en = 0; m_pend = 0; end
            1: if (held) m_tgt = m_tgt | d;
            2: if (held) m_tgt = m_tgt & ~d;
            4: if (held) m_en = m_en | d;
            5: if (held) m_en = m_en & ~d;
            7: if (held) m_pend = d[0];
            default: ;
        endcase
    endtask

    function automatic logic [N-1:0] model_read(input int a);
        case (a)
            0: return m_own;
            3: return m_tgt;
            6: return m_en;
            7: return {{(N-1){1'b0}}, m_pend};
            default: return '0;
        endcase
    endfunction

    task automatic wr(input int a, input logic [N-1:0] d);
        bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
        @(posedge clk);
        model_write(a, d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, input string tag);
        bus_addr = 3'(a);
        #1;
        chk(tag, bus_rdata, model_read(a));
    endtask

    task automatic rd_exp(input int a, input logic [N-1:0] exp, input string tag);
        bus_addr = 3'(a);
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    // R10: interrupt lines against the model on every clock
    always @(negedge clk) begin
        if (live && !done) chk("R10 irq per-cycle", irq_out, m_pend ? (m_tgt & m_en) : '0);
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;
        // R1 reset state
        rd_exp(0, '0, "R1 owner");
        rd_exp(3, '0, "R1 target");
        rd_exp(6, '0, "R1 enable");
        rd_exp(7, '0, "R1 pending");
        chk("R1 irq", irq_out, '0);
        // R8 writes ignored while free
        wr(1, 32'hFF); wr(4, 32'hFF); wr(7, 1);
        rd_exp(3, '0, "R8 target free");
        rd_exp(6, '0, "R8 enable free");
        rd_exp(7, '0, "R8 send free");
        // R2 claim by core with id bit 3
        wr(0, 32'h8);
        rd_exp(0, 32'h8, "R2 claim readback");
        // R3 contender with bit 5 loses
        wr(0, 32'h20);
        rd_exp(0, 32'h8, "R3 loser sees owner");
        // R5 / R6 target
        wr(1, 32'h20); wr(1, 32'h4);
        rd_exp(3, 32'h24, "R5 target or");
        wr(2, 32'h20);
        rd_exp(3, 32'h4, "R6 target clear");
        // R7 enable
        wr(4, 32'h6); wr(5, 32'h2);
        rd_exp(6, 32'h4, "R7 enable set/clear");
        // R9 / R10 send
        wr(7, 1);
        rd_exp(7, 1, "R9 pending set");
        chk("R10 irq single", irq_out, 32'h4);
        wr(1, 32'h100); wr(4, 32'h100);
        chk("R10 irq two", irq_out, 32'h104);
        wr(5, 32'h4);
        chk("R10 irq enable dropped", irq_out, 32'h100);
        wr(7, 0);
        rd_exp(7, 0, "R9 pending clear");
        chk("R10 irq off", irq_out, '0);
        wr(7, 1);
        // R4 release wipes all
        wr(0, 0);
        rd_exp(0, '0, "R4 owner");
        rd_exp(3, '0, "R4 target");
        rd_exp(6, '0, "R4 enable");
        rd_exp(7, '0, "R4 pending");
        chk("R4 irq", irq_out, '0);
        // R2 non-one-hot stored as given
        wr(0, 32'h81);
        rd_exp(0, 32'h81, "R2 raw value");
        wr(0, 0);
        // random stream against the model
        for (int i = 0; i < 3000; i++) begin
            int a = $urandom_range(0, 7);
            logic [N-1:0] d = $urandom;
            if (a == 0 && ($urandom_range(0, 3) == 0)) d = '0;
            if (a == 0 && ($urandom_range(0, 1) == 0)) d = 32'(1) << $urandom_range(0, N - 1);
            wr(a, d);
            rd($urandom_range(0, 7), "R5 R6 R7 R9 random readback");
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule